// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block turns a processor's 3-bit bus-cycle status code into the strobes a system bus needs. The processor does not drive read or write strobes itself. It reports what kind of cycle it is running, and it leaves the status lines at the passive code (111) when no cycle is in progress. The generator starts a bus cycle when the status moves away from the passive code. It captures the cycle type and then sequences the address latch strobe, the data buffer enable, the buffer direction line and one active-low command strobe across the cycle's phases.

One clock equals one phase. A READY input stretches a cycle: while READY is low, a cycle in progress keeps its commands and does not advance or finish. Halt cycles produce only an address latch pulse. Code-fetch and data-read cycles both produce the memory read command.

Top module: `busCmdGen`

## Requirements
- R1: Out of reset, every command strobe (memRdN, memWrN, ioRdN, ioWrN, intAckN) is high, and addrLatch, dataEn and dirTx are low.
- R2: When the status is sampled at 111 on one rising edge and at any other code on the next, addrLatch is high for exactly the one clock after that second edge. No command strobe is low while addrLatch is high.
- R3: From the second clock after the start, a single strobe is low, chosen by the captured code: 000 → intAckN, 001 → ioRdN, 010 → ioWrN, 100 or 101 → memRdN, 110 → memWrN.
- R4: A command ends (strobe high, dataEn low) in the clock after the edge that samples status 111 with ready high.
- R5: For write codes (010, 110), dataEn rises together with the command. For read codes and intAck (000, 001, 100, 101), dataEn rises one phase later, once a phase boundary has passed with ready high.
- R6: dirTx is high from the latch phase until the end of a write cycle, and low for all other cycles and when idle.
- R7: Code 011 (halt) gives the latch pulse only, with no command and no dataEn. No new cycle starts until the status has returned to 111.
- R8: While ready is low during the command phases, the command strobes and dataEn hold their values, and a return to 111 does not end the cycle.
- R9: The cycle type is captured at the start. A change of the status between non-passive codes during a cycle has no effect on the strobes.
- R10: At most one command strobe is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus phase per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| statusCode | input | 3 | Bus-cycle type reported by the processor; 111 is passive |
| ready | input | 1 | High when the addressed device can finish the cycle |
| addrLatch | output | 1 | Address latch strobe, one phase at cycle start |
| dataEn | output | 1 | Data buffer enable |
| dirTx | output | 1 | Data buffer direction, high for write (transmit) |
| memRdN | output | 1 | Memory read command, active low |
| memWrN | output | 1 | Memory write command, active low |
| ioRdN | output | 1 | I/O read command, active low |
| ioWrN | output | 1 | I/O write command, active low |
| intAckN | output | 1 | Interrupt acknowledge command, active low |

## Verification
The end of one cycle and the start-detection window of the next can meet. A command phase that samples 111 with ready high returns to idle at the same edge that loads the passive sample, so a new code driven right afterwards must produce a latch pulse without a lost or extra clock. A wait state can also coincide with the status already back at 111. The bench provokes both with random status and ready streams biased toward short holds, plus directed back-to-back and stretched cycles. Each phase is judged against a bench reference model of the phase sequence.

// File: rtl/busCmdPkg.sv
package busCmdPkg;

  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] CODE_INTA  = 3'b000;
  localparam logic [CODE_W-1:0] CODE_IORD  = 3'b001;
  localparam logic [CODE_W-1:0] CODE_IOWR  = 3'b010;
  localparam logic [CODE_W-1:0] CODE_HALT  = 3'b011;
  localparam logic [CODE_W-1:0] CODE_FETCH = 3'b100;
  localparam logic [CODE_W-1:0] CODE_MEMRD = 3'b101;
  localparam logic [CODE_W-1:0] CODE_MEMWR = 3'b110;
  localparam logic [CODE_W-1:0] CODE_IDLE  = 3'b111;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LATCH,
    PH_CMD,
    PH_DATA,
    PH_HALTWAIT
  } phase_t;

  typedef struct packed {
    logic capture;
    logic latchOn;
    logic cmdOn;
    logic earlyDe;
    logic lateDe;
    logic cycleOn;
  } ctlStrobes_t;

endpackage

// File: rtl/busCmdCtrl.sv
module busCmdCtrl
  import busCmdPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startSeen,
  input  logic        passiveNow,
  input  logic        haltType,
  input  logic        ready,
  output ctlStrobes_t strb
);

  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:     if (startSeen) phaseNext = PH_LATCH;
      PH_LATCH:    phaseNext = haltType ? PH_HALTWAIT : PH_CMD;
      PH_CMD: begin
        if (ready) phaseNext = passiveNow ? PH_IDLE : PH_DATA;
      end
      PH_DATA:     if (ready && passiveNow) phaseNext = PH_IDLE;
      PH_HALTWAIT: if (passiveNow) phaseNext = PH_IDLE;
      default:     phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strb.capture = (phase == PH_IDLE) && startSeen;
    strb.latchOn = (phase == PH_LATCH);
    strb.cmdOn   = (phase == PH_CMD) || (phase == PH_DATA);
    strb.earlyDe = strb.cmdOn;
    strb.lateDe  = (phase == PH_DATA);
    strb.cycleOn = (phase == PH_LATCH) || strb.cmdOn;
  end

endmodule

// File: rtl/busCmdPath.sv
module busCmdPath
  import busCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] statusCode,
  input  ctlStrobes_t       strb,
  output logic              startSeen,
  output logic              passiveNow,
  output logic              haltType,
  output logic              addrLatch,
  output logic              dataEn,
  output logic              dirTx,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic              intAckN
);

  logic [CODE_W-1:0] prevCode;
  logic [CODE_W-1:0] cycType;
  logic isWrite, isReadish;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCode <= CODE_IDLE;
      cycType  <= CODE_IDLE;
    end else begin
      prevCode <= statusCode;
      if (strb.capture) cycType <= statusCode;
    end
  end

  assign passiveNow = (statusCode == CODE_IDLE);
  assign startSeen  = (prevCode == CODE_IDLE) && !passiveNow;
  assign haltType   = (cycType == CODE_HALT);

  assign isWrite   = (cycType == CODE_IOWR) || (cycType == CODE_MEMWR);
  assign isReadish = (cycType == CODE_INTA) || (cycType == CODE_IORD) ||
                     (cycType == CODE_FETCH) || (cycType == CODE_MEMRD);

  assign addrLatch = strb.latchOn;
  assign dirTx     = strb.cycleOn && isWrite;
  assign dataEn    = (strb.earlyDe && isWrite) || (strb.lateDe && isReadish);

  assign memRdN  = !(strb.cmdOn && ((cycType == CODE_FETCH) || (cycType == CODE_MEMRD)));
  assign memWrN  = !(strb.cmdOn && (cycType == CODE_MEMWR));
  assign ioRdN   = !(strb.cmdOn && (cycType == CODE_IORD));
  assign ioWrN   = !(strb.cmdOn && (cycType == CODE_IOWR));
  assign intAckN = !(strb.cmdOn && (cycType == CODE_INTA));

endmodule

// File: rtl/busCmdGen.sv
module busCmdGen
  import busCmdPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  statusCode,
  input  logic        ready,
  output logic        addrLatch,
  output logic        dataEn,
  output logic        dirTx,
  output logic        memRdN,
  output logic        memWrN,
  output logic        ioRdN,
  output logic        ioWrN,
  output logic        intAckN
);

  ctlStrobes_t strb;
  logic startSeen, passiveNow, haltType;

  busCmdCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startSeen  (startSeen),
    .passiveNow (passiveNow),
    .haltType   (haltType),
    .ready      (ready),
    .strb       (strb)
  );

  busCmdPath u_path (
    .clk        (clk),
    .rstN       (rstN),
    .statusCode (statusCode),
    .strb       (strb),
    .startSeen  (startSeen),
    .passiveNow (passiveNow),
    .haltType   (haltType),
    .addrLatch  (addrLatch),
    .dataEn     (dataEn),
    .dirTx      (dirTx),
    .memRdN     (memRdN),
    .memWrN     (memWrN),
    .ioRdN      (ioRdN),
    .ioWrN      (ioWrN),
    .intAckN    (intAckN)
  );

endmodule

// File: rtl/busCmdGenChk.sv
module busCmdGenChk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] statusCode,
  input logic       ready,
  input logic       addrLatch,
  input logic       dataEn,
  input logic       dirTx,
  input logic       memRdN,
  input logic       memWrN,
  input logic       ioRdN,
  input logic       ioWrN,
  input logic       intAckN
);

  logic [4:0] cmdAct;
  assign cmdAct = ~{memRdN, memWrN, ioRdN, ioWrN, intAckN};

  // R10: never two commands at once
  a_r10_single_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdAct));

  // R2: latch pulse lasts one phase
  a_r2_latch_one: assert property (@(posedge clk) disable iff (!rstN)
    addrLatch |=> !addrLatch);

  // R2: no command during the latch phase
  a_r2_latch_no_cmd: assert property (@(posedge clk) disable iff (!rstN)
    addrLatch |-> (cmdAct == 5'b0));

  // R6: direction follows the command kind
  a_r6_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    (!memWrN || !ioWrN) |-> dirTx);
  a_r6_dir_read: assert property (@(posedge clk) disable iff (!rstN)
    (!memRdN || !ioRdN || !intAckN) |-> !dirTx);

  // R5: writes have the buffer enabled with the command
  a_r5_write_de: assert property (@(posedge clk) disable iff (!rstN)
    (!memWrN || !ioWrN) |-> dataEn);

  // R7: buffer is only enabled inside a commanded cycle
  a_r7_de_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> (cmdAct != 5'b0));

  // R8: wait state holds commands and enable
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdAct != 5'b0) && !ready) |=> ($stable(cmdAct) && $stable(dataEn)));

  // R4: passive with ready ends the command
  a_r4_end: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdAct != 5'b0) && ready && (statusCode == 3'b111)) |=> ((cmdAct == 5'b0) && !dataEn));

endmodule

bind busCmdGen busCmdGenChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .statusCode (statusCode),
  .ready      (ready),
  .addrLatch  (addrLatch),
  .dataEn     (dataEn),
  .dirTx      (dirTx),
  .memRdN     (memRdN),
  .memWrN     (memWrN),
  .ioRdN      (ioRdN),
  .ioWrN      (ioWrN),
  .intAckN    (intAckN)
);

// File: tb/busCmdGen_tb.sv
`timescale 1ns/1ps
module busCmdGen_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] statusCode = 3'b111;
  logic ready = 1'b1;
  logic addrLatch, dataEn, dirTx, memRdN, memWrN, ioRdN, ioWrN, intAckN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  busCmdGen u_dut (
    .clk(clk), .rstN(rstN), .statusCode(statusCode), .ready(ready),
    .addrLatch(addrLatch), .dataEn(dataEn), .dirTx(dirTx),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .intAckN(intAckN)
  );

  // reference model: 0 idle, 1 latch, 2 command, 3 data, 4 halt wait
  int mPhase = 0;
  logic [2:0] mPrev = 3'b111;
  logic [2:0] mType = 3'b111;

  function automatic logic isWr(logic [2:0] t);
    return (t == 3'b010) || (t == 3'b110);
  endfunction

  function automatic logic isRd(logic [2:0] t);
    return (t == 3'b000) || (t == 3'b001) || (t == 3'b100) || (t == 3'b101);
  endfunction

  function automatic logic [7:0] expOut();
    logic cmd;
    logic [7:0] v;
    cmd  = (mPhase == 2) || (mPhase == 3);
    v[7] = (mPhase == 1);
    v[6] = (cmd && isWr(mType)) || ((mPhase == 3) && isRd(mType));
    v[5] = (mPhase >= 1) && (mPhase <= 3) && isWr(mType);
    v[4] = !(cmd && ((mType == 3'b100) || (mType == 3'b101)));
    v[3] = !(cmd && (mType == 3'b110));
    v[2] = !(cmd && (mType == 3'b001));
    v[1] = !(cmd && (mType == 3'b010));
    v[0] = !(cmd && (mType == 3'b000));
    return v;
  endfunction

  task automatic modelStep(input logic [2:0] st, input logic rdy);
    case (mPhase)
      0: if (mPrev == 3'b111 && st != 3'b111) begin mType = st; mPhase = 1; end
      1: mPhase = (mType == 3'b011) ? 4 : 2;
      2: if (rdy) mPhase = (st == 3'b111) ? 0 : 3;
      3: if (rdy && st == 3'b111) mPhase = 0;
      4: if (st == 3'b111) mPhase = 0;
      default: mPhase = 0;
    endcase
    mPrev = st;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic checkModel();
    logic [7:0] e;
    e = expOut();
    chk("R2", "addrLatch", addrLatch, e[7]);
    chk("R5", "dataEn", dataEn, e[6]);
    chk("R6", "dirTx", dirTx, e[5]);
    chk("R3", "memRdN", memRdN, e[4]);
    chk("R3", "memWrN", memWrN, e[3]);
    chk("R3", "ioRdN", ioRdN, e[2]);
    chk("R3", "ioWrN", ioWrN, e[1]);
    chk("R3", "intAckN", intAckN, e[0]);
  endtask

  // drive at negedge, let one edge pass, sample at next negedge
  task automatic step(input logic [2:0] st, input logic rdy);
    statusCode = st;
    ready = rdy;
    modelStep(st, rdy);
    @(posedge clk);
    @(negedge clk);
    checkModel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] cur;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "memRdN", memRdN, 1'b1);
    chk("R1", "memWrN", memWrN, 1'b1);
    chk("R1", "ioRdN", ioRdN, 1'b1);
    chk("R1", "ioWrN", ioWrN, 1'b1);
    chk("R1", "intAckN", intAckN, 1'b1);
    chk("R1", "addrLatch", addrLatch, 1'b0);
    chk("R1", "dataEn", dataEn, 1'b0);
    chk("R1", "dirTx", dirTx, 1'b0);
    rstN = 1'b1;
    step(3'b111, 1'b1);

    // memory read: latch, command, late enable, end
    step(3'b101, 1'b1);
    chk("R2", "latch on start", addrLatch, 1'b1);
    step(3'b101, 1'b1);
    chk("R3", "memRdN low", memRdN, 1'b0);
    chk("R5", "read enable not yet", dataEn, 1'b0);
    step(3'b101, 1'b1);
    chk("R5", "read enable late", dataEn, 1'b1);
    step(3'b111, 1'b1);
    chk("R4", "memRdN released", memRdN, 1'b1);

    // memory write with a wait state at the end
    step(3'b110, 1'b1);
    chk("R6", "dir in latch phase", dirTx, 1'b1);
    step(3'b110, 1'b1);
    chk("R5", "write enable early", dataEn, 1'b1);
    step(3'b111, 1'b0);
    chk("R8", "memWrN held", memWrN, 1'b0);
    step(3'b111, 1'b1);
    chk("R4", "memWrN released", memWrN, 1'b1);
    chk("R6", "dir released", dirTx, 1'b0);

    // halt: latch only, no restart while held
    step(3'b011, 1'b1);
    chk("R7", "halt latch", addrLatch, 1'b1);
    for (int i = 0; i < 3; i++) begin
      step(3'b011, 1'b1);
      chk("R7", "halt no relatch", addrLatch, 1'b0);
      chk("R7", "halt no enable", dataEn, 1'b0);
      chk("R7", "halt no memRd", memRdN, 1'b1);
    end
    step(3'b111, 1'b1);
    // I/O read started straight after, then a mid-cycle code change
    step(3'b001, 1'b1);
    chk("R2", "latch after halt", addrLatch, 1'b1);
    step(3'b110, 1'b1);
    chk("R9", "ioRdN kept", ioRdN, 1'b0);
    chk("R9", "memWrN ignored", memWrN, 1'b1);
    step(3'b111, 1'b1);

    // interrupt acknowledge with wait states in the command phase
    step(3'b000, 1'b1);
    step(3'b000, 1'b0);
    chk("R3", "intAckN low", intAckN, 1'b0);
    step(3'b000, 1'b0);
    chk("R8", "enable held off", dataEn, 1'b0);
    step(3'b111, 1'b0);
    chk("R8", "no end while not ready", intAckN, 1'b0);
    step(3'b111, 1'b1);
    chk("R4", "intAckN released", intAckN, 1'b1);

    // code fetch and I/O write
    step(3'b100, 1'b1);
    step(3'b100, 1'b1);
    chk("R3", "fetch gives memRdN", memRdN, 1'b0);
    step(3'b111, 1'b1);
    step(3'b010, 1'b1);
    step(3'b010, 1'b1);
    chk("R3", "ioWrN low", ioWrN, 1'b0);
    chk("R6", "dir io write", dirTx, 1'b1);
    step(3'b111, 1'b1);

    // random phase stream
    cur = 3'b111;
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4)      cur = cur;
      else if (r < 7) cur = 3'b111;
      else            cur = 3'($urandom_range(0, 7));
      step(cur, ($urandom_range(0, 4) != 0));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule